// File: doc/BRIEF.md
# Scheduled Power-Off Alarm Controller

This block lets software schedule the moment at which an external power-management device switches the system off. It holds a second alarm time made of six BCD fields: seconds, minutes, hours, day, month and year. On every time-update strobe it compares that alarm time with the running calendar time, which a separate timekeeping counter supplies as BCD inputs.

A match always sets a sticky status flag. If the matching interrupt enable is set, the match also raises an interrupt. If software has armed pin control, the same match drives the power-enable output low. The output then stays low until reset, so the external device can cut power at the scheduled instant. The output changes on the clock edge that samples the matching update, which is well within the minimum two-second scheduling window that software uses.

Registers are written through a simple write port that carries a full-word qualifier, and read through a combinational read port.

Top module: `pwroff_alarm_ctrl`

## Requirements
- R1: After reset, `pwr_en` is 1, `irq` is 0, and every register reads as 0.
- R2: The six alarm fields are byte registers at offsets 0x80 (seconds), 0x84 (minutes), 0x88 (hours), 0x8C (day), 0x90 (month) and 0x94 (year). A write of either size stores `wr_data[7:0]`, and a read returns that byte in bits 7:0 with zeros above.
- R3: On a cycle with `tick` high, the status flag (bit 7 of offset 0x44) is set when all six alarm fields equal the matching bytes of `cur_time`. Those bytes are seconds in [7:0], minutes in [15:8], hours in [23:16], day in [31:24], month in [39:32] and year in [47:40]. A difference in any single bit of any field prevents the set.
- R4: Writing offset 0x44 with bit 7 equal to 1 clears the status flag, and writing bit 7 equal to 0 leaves it unchanged. When a match and a clear occur in the same cycle, the flag ends up set.
- R5: The interrupt enable is bit 4 of offset 0x48. It changes only on a full-word write (`wr_word` = 1); a byte write to that offset is ignored.
- R6: `irq` is high exactly while both the status flag and the interrupt enable are set.
- R7: Pin control is armed by bit 16 of offset 0x98, which only full-word writes update. While armed, a matching tick drives `pwr_en` to 0 on the same clock edge that sets the status flag.
- R8: While pin control is not armed, a match leaves `pwr_en` at 1.
- R9: Once `pwr_en` is 0, it stays 0 until reset, whatever is later written to the control, status or enable registers.
- R10: A matching `cur_time` presented without `tick` has no effect on the status flag or on `pwr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Time-update strobe; compare is evaluated when high |
| cur_time | input | 48 | Current BCD time: {year, month, day, hours, minutes, seconds} |
| wr_en | input | 1 | Register write strobe |
| wr_word | input | 1 | 1 for a full 32-bit write, 0 for a byte write |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 8 | Read byte offset |
| rd_data | output | 32 | Read data for `rd_addr` |
| irq | output | 1 | Second-alarm interrupt |
| pwr_en | output | 1 | Power-enable pin to the external power device; 0 means off |

## Verification
The bench sweeps every single-bit disagreement across all 48 compare bits. A compare that ignored a field or a bit would set the status flag on one of those near-misses. It presents a matching time without the strobe, and a design that compared on every cycle would flag it.

A byte write to the enable register must change nothing, so a design without the full-word qualifier turns the interrupt on too early. A clear that coincides with a match must leave the flag set, and reversing that priority loses the event. Finally, the bench disarms and clears everything after the pin has dropped and checks that the pin stays low until reset. It also checks that an unarmed match never moves the pin.

// File: rtl/pwroff_pkg.sv
package pwroff_pkg;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 32;
  localparam int NFIELD     = 6;
  localparam int FIELD_W    = 8;
  localparam int TIME_W     = NFIELD * FIELD_W;
  localparam int FIELD_STEP = 4;

  localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_INTEN    = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_ALM_BASE = 8'h80;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 8'h98;

  localparam int BIT_STATUS = 7;
  localparam int BIT_IE     = 4;
  localparam int BIT_ARM    = 16;

  typedef logic [TIME_W-1:0] bcd_time_t;
endpackage

// File: rtl/pwroff_alarm_bank.sv
module pwroff_alarm_bank
  import pwroff_pkg::*;
#(
  parameter int N_F   = NFIELD,
  parameter int F_W   = FIELD_W,
  parameter int A_W   = ADDR_W,
  parameter int BASE  = 128,
  parameter int STEP  = FIELD_STEP
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [A_W-1:0]   wr_addr,
  input  logic [F_W-1:0]   wr_byte,
  output logic [N_F*F_W-1:0] alarm_o
);
  for (genvar g = 0; g < N_F; g++) begin : g_field
    localparam logic [A_W-1:0] FADDR = A_W'(BASE + STEP * g);
    logic           sel;
    logic [F_W-1:0] fld_q, fld_d;

    assign sel = wr_en && (wr_addr == FADDR);

    always_comb begin
      fld_d = fld_q;
      if (sel) fld_d = wr_byte;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   fld_q <= '0;
      else if (sel) fld_q <= fld_d;
    end

    assign alarm_o[g*F_W +: F_W] = fld_q;
  end
endmodule

// File: rtl/pwroff_cmp.sv
module pwroff_cmp
  import pwroff_pkg::*;
#(
  parameter int N_F = NFIELD,
  parameter int F_W = FIELD_W
) (
  input  logic [N_F*F_W-1:0] alarm_i,
  input  logic [N_F*F_W-1:0] now_i,
  output logic               hit_o
);
  logic [N_F-1:0] eq;

  for (genvar g = 0; g < N_F; g++) begin : g_eq
    assign eq[g] = (alarm_i[g*F_W +: F_W] == now_i[g*F_W +: F_W]);
  end

  assign hit_o = &eq;
endmodule

// File: rtl/pwroff_ctrl.sv
module pwroff_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hit,
  input  logic status_wr,
  input  logic status_clr,
  input  logic ie_wr,
  input  logic ie_val,
  input  logic arm_wr,
  input  logic arm_val,
  output logic status_q,
  output logic ie_q,
  output logic arm_q,
  output logic pwr_q,
  output logic irq
);
  logic event_hit;
  logic status_d, ie_d, arm_d, pwr_d;
  logic status_en, pwr_en_ce;

  assign event_hit = tick && hit;

  always_comb begin
    status_en = event_hit || (status_wr && status_clr);
    status_d  = event_hit ? 1'b1 : 1'b0;
    ie_d      = ie_val;
    arm_d     = arm_val;
    pwr_en_ce = event_hit && arm_q;
    pwr_d     = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= 1'b0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= 1'b0;
    end else if (ie_wr) begin
      ie_q <= ie_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
    end else if (arm_wr) begin
      arm_q <= arm_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q <= 1'b1;
    end else if (pwr_en_ce) begin
      pwr_q <= pwr_d;
    end
  end

  assign irq = status_q && ie_q;
endmodule

// File: rtl/pwroff_alarm_ctrl.sv
module pwroff_alarm_ctrl
  import pwroff_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [TIME_W-1:0] cur_time,
  input  logic              wr_en,
  input  logic              wr_word,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              pwr_en
);
  logic [1:0]  rst_sync;
  logic        rst_sync_n;
  bcd_time_t   alarm_q;
  logic        cmp_hit;
  logic        status_q, ie_q, arm_q;
  logic        wr_status, wr_inten, wr_ctrl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  assign wr_status = wr_en && (wr_addr == OFS_STATUS);
  assign wr_inten  = wr_en && wr_word && (wr_addr == OFS_INTEN);
  assign wr_ctrl   = wr_en && wr_word && (wr_addr == OFS_CTRL);

  pwroff_alarm_bank #(
    .N_F (NFIELD),
    .F_W (FIELD_W),
    .A_W (ADDR_W),
    .BASE(int'(OFS_ALM_BASE)),
    .STEP(FIELD_STEP)
  ) u_bank (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_byte(wr_data[FIELD_W-1:0]),
    .alarm_o(alarm_q)
  );

  pwroff_cmp #(
    .N_F(NFIELD),
    .F_W(FIELD_W)
  ) u_cmp (
    .alarm_i(alarm_q),
    .now_i  (cur_time),
    .hit_o  (cmp_hit)
  );

  pwroff_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .tick      (tick),
    .hit       (cmp_hit),
    .status_wr (wr_status),
    .status_clr(wr_data[BIT_STATUS]),
    .ie_wr     (wr_inten),
    .ie_val    (wr_data[BIT_IE]),
    .arm_wr    (wr_ctrl),
    .arm_val   (wr_data[BIT_ARM]),
    .status_q  (status_q),
    .ie_q      (ie_q),
    .arm_q     (arm_q),
    .pwr_q     (pwr_en),
    .irq       (irq)
  );

  always_comb begin
    rd_data = '0;
    if (rd_addr == OFS_STATUS) rd_data[BIT_STATUS] = status_q;
    if (rd_addr == OFS_INTEN)  rd_data[BIT_IE]     = ie_q;
    if (rd_addr == OFS_CTRL)   rd_data[BIT_ARM]    = arm_q;
    for (int i = 0; i < NFIELD; i++) begin
      if (rd_addr == ADDR_W'(int'(OFS_ALM_BASE) + FIELD_STEP * i))
        rd_data[FIELD_W-1:0] = alarm_q[i*FIELD_W +: FIELD_W];
    end
  end
endmodule

// File: rtl/pwroff_chk.sv
module pwroff_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic hit,
  input logic arm,
  input logic status,
  input logic ie,
  input logic irq,
  input logic pwr_en
);
  AST_PIN_LATCHED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |=> !pwr_en); // R9
  AST_PIN_DROP_ON_ARMED_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit && arm) |=> !pwr_en); // R7
  AST_PIN_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(tick && hit && arm)); // R7
  AST_UNARMED_KEEPS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_en && !arm) |=> pwr_en); // R8
  AST_STATUS_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && hit) |=> status); // R3
  AST_STATUS_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status) |-> $past(tick && hit)); // R10
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && status)); // R6
endmodule

bind pwroff_alarm_ctrl pwroff_chk u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .tick  (tick),
  .hit   (cmp_hit),
  .arm   (arm_q),
  .status(status_q),
  .ie    (ie_q),
  .irq   (irq),
  .pwr_en(pwr_en)
);

// File: tb/tb_pwroff_alarm_ctrl.sv
module tb_pwroff_alarm_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [47:0] cur_time = '0;
  logic        wr_en = 1'b0;
  logic        wr_word = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq;
  logic        pwr_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  localparam logic [47:0] T0 = {8'h31, 8'h07, 8'h22, 8'h15, 8'h34, 8'h12};

  always #4 clk = ~clk;

  pwroff_alarm_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cur_time(cur_time),
    .wr_en(wr_en), .wr_word(wr_word), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq), .pwr_en(pwr_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit word);
    @(negedge clk);
    wr_en = 1'b1; wr_word = word; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_word = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic do_tick(input logic [47:0] t);
    @(negedge clk);
    cur_time = t; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [47:0] t;
    do_reset();

    // R1 reset state
    chk("R1 pwr_en", {31'd0, pwr_en}, 32'd1);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h44, d); chk("R1 status", d, 0);
    rd(8'h48, d); chk("R1 inten", d, 0);
    rd(8'h98, d); chk("R1 ctrl", d, 0);
    for (int k = 0; k < 6; k++) begin
      rd(8'(8'h80 + 4 * k), d); chk("R1 alarm field", d, 0);
    end

    // R2 alarm fields, upper write bits discarded, mixed sizes
    for (int k = 0; k < 6; k++) begin
      wr(8'(8'h80 + 4 * k), {24'hABCDEF, T0[k*8 +: 8]}, k[0]);
    end
    for (int k = 0; k < 6; k++) begin
      rd(8'(8'h80 + 4 * k), d); chk("R2 alarm readback", d, {24'd0, T0[k*8 +: 8]});
    end

    // R10 matching time without tick
    @(negedge clk); cur_time = T0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rd(8'h44, d); chk("R10 no tick status", d, 0);
    chk("R10 no tick pwr_en", {31'd0, pwr_en}, 32'd1);

    // R3 single-bit mismatch sweep over all 48 bits
    for (int b = 0; b < 48; b++) begin
      t = T0 ^ (48'd1 << b);
      do_tick(t);
      rd(8'h44, d); chk("R3 near miss no status", d, 0);
    end

    // R3 / R8 / R6 unarmed match
    do_tick(T0);
    rd(8'h44, d); chk("R3 match sets status", d, 32'h80);
    chk("R8 unarmed pin stays on", {31'd0, pwr_en}, 32'd1);
    chk("R6 irq off when disabled", {31'd0, irq}, 32'd0);

    // R5 byte write ignored, word write takes effect
    wr(8'h48, 32'h10, 1'b0);
    rd(8'h48, d); chk("R5 byte write ignored", d, 0);
    chk("R5 irq after byte write", {31'd0, irq}, 32'd0);
    wr(8'h48, 32'h10, 1'b1);
    rd(8'h48, d); chk("R5 word write enables", d, 32'h10);
    chk("R6 irq on", {31'd0, irq}, 32'd1);

    // R4 write-one-to-clear
    wr(8'h44, 32'h0, 1'b1);
    rd(8'h44, d); chk("R4 zero write keeps", d, 32'h80);
    wr(8'h44, 32'h80, 1'b0);
    rd(8'h44, d); chk("R4 one clears", d, 0);
    chk("R6 irq off after clear", {31'd0, irq}, 32'd0);

    // R4 set wins over simultaneous clear
    @(negedge clk);
    cur_time = T0; tick = 1'b1;
    wr_en = 1'b1; wr_word = 1'b1; wr_addr = 8'h44; wr_data = 32'h80;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; wr_word = 1'b0;
    rd(8'h44, d); chk("R4 set beats clear", d, 32'h80);
    wr(8'h44, 32'h80, 1'b1);

    // R7 arm, byte write to ctrl ignored
    wr(8'h98, 32'h0001_0000, 1'b0);
    rd(8'h98, d); chk("R7 byte write to ctrl ignored", d, 0);
    wr(8'h98, 32'h0001_0000, 1'b1);
    rd(8'h98, d); chk("R7 armed readback", d, 32'h0001_0000);
    do_tick(T0 ^ 48'h0100_0000_0000);
    chk("R7 armed near miss pin on", {31'd0, pwr_en}, 32'd1);
    @(negedge clk); cur_time = T0; tick = 1'b1;
    #1 chk("R7 pin on before edge", {31'd0, pwr_en}, 32'd1);
    @(negedge clk); tick = 1'b0;
    chk("R7 pin off after matching edge", {31'd0, pwr_en}, 32'd0);
    rd(8'h44, d); chk("R7 status with pin drop", d, 32'h80);

    // R9 latched off until reset
    wr(8'h98, 32'h0, 1'b1);
    wr(8'h44, 32'h80, 1'b1);
    wr(8'h48, 32'h0, 1'b1);
    do_tick(T0 ^ 48'h1);
    repeat (3) @(negedge clk);
    chk("R9 pin stays off", {31'd0, pwr_en}, 32'd0);
    do_reset();
    chk("R9 reset restores pin", {31'd0, pwr_en}, 32'd1);
    rd(8'h80, d); chk("R1 alarm cleared by reset", d, 0);

    finish_run();
  end
endmodule